// File: doc/BRIEF.md
# Fractional-N LO Parameter Calculator

This block turns a requested RF carrier frequency, given in hertz, into the three numbers a fixed-modulus fractional-N synthesizer needs. The first is a power-of-two output divider code. The second is the integer part of the feedback ratio and the third is its fractional part. The fractional modulus is the odd constant 8388593. The block also reports the LO frequency those words actually produce, rounded to the nearest hertz, and the matching VCO frequency.

The reference frequency input is the PLL reference after the pin clock has been scaled by 0.25, 0.5, 1 or 2. That scaling is done outside this block.

A one-cycle `start_i` pulse launches a calculation. The block uses one restoring divider that produces one quotient bit per clock. It runs that divider three times: once for the integer word, once for the rounded fraction, and once for the rounded LO frequency. While the block is busy it ignores its inputs. When it finishes, it raises `done_o` for one cycle. Its outputs then hold until the next calculation completes. A request it cannot serve raises `error_o` and clears every parameter output.

Top module: `lo_param_calc`

## Requirements
- R1: A target frequency above 6,000,000,000 Hz, below 46,875,000 Hz, or exactly 6,000,000,000 Hz completes with `error_o`=1. In that case `code_o`, `int_o`, `frac_o`, `vco_o` and `lo_o` are all 0.
- R2: For a valid target f, let k be the smallest count of doublings (k ≥ 1) that brings f·2^k to 6,000,000,000 or above. Then `code_o` = k−1, and the internal VCO frequency f·2^(code+1) lies in [6 GHz, 12 GHz).
- R3: Before any carry, the integer word is floor(VCO / ref), and r = VCO mod ref.
- R4: The fractional word is floor((2·r·8388593 + ref) / (2·ref)), which is the fraction rounded half up. It is 23 bits wide and always below 8388593.
- R5: If the rounded fraction reaches 8388593 or more, 8388593 is subtracted from it and the integer word grows by one.
- R6: `lo_o` = floor((ref·(int·8388593 + frac) + 8388593·2^code) / (8388593·2^(code+1))), which is the synthesized LO frequency rounded to the nearest hertz.
- R7: `vco_o` = `lo_o`·2^(code+1).
- R8: A reference of 0, or a final integer word of 2^INT_W or more, completes with `error_o`=1 and all parameter outputs 0.
- R9: On a valid request, `busy_o` is 1 one cycle after `start_i` is sampled. `done_o` pulses for exactly one cycle, with `busy_o` low. The outputs hold their values after `done_o` falls. A successful completion clears `error_o`.
- R10: A `start_i` pulse while `busy_o` is 1 has no effect, and the result reflects the request that started the run.
- R11: After reset, `busy_o`, `done_o`, `error_o` and all parameter outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request strobe |
| freq_i | input | FREQ_W (33) | Requested carrier frequency in Hz |
| ref_i | input | REF_W (32) | PLL reference frequency in Hz |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Last request was rejected |
| code_o | output | 3 | Output divider code; the division ratio is 2^(code+1) |
| int_o | output | INT_W (16) | Integer feedback word |
| frac_o | output | FRAC_W (23) | Fractional feedback word, modulus 8388593 |
| vco_o | output | FREQ_W+1 (34) | Resulting VCO frequency in Hz |
| lo_o | output | FREQ_W (33) | Resulting LO frequency in Hz |

## Verification
The bench builds the block with its default widths: a 33-bit target, a 32-bit reference, a 16-bit integer word and a 23-bit fraction. With a 16-bit integer word, a 100 kHz reference pushes the integer word past its limit, so the overflow error path can be reached. A 40 MHz reference makes the fraction-carry path reachable: it is above twice the modulus, so a remainder one or two hertz short of the reference rounds the fraction up to the full modulus. With a 33-bit target, the exact 6 GHz edge and the values just above and below it can all be presented, together with the lowest accepted target, which needs the deepest divider code.

// File: rtl/lo_param_pkg.sv
package lo_param_pkg;

  localparam int unsigned CODE_W        = 3;
  localparam int unsigned MAX_DOUBLINGS = 7;

  localparam longint unsigned VCO_LOW_HZ    = 64'd6000000000;
  localparam longint unsigned VCO_HIGH_HZ   = 64'd12000000000;
  localparam longint unsigned TARGET_MIN_HZ = 64'd46875000;
  localparam longint unsigned FRAC_MODULUS  = 64'd8388593;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INT,
    ST_FRAC,
    ST_LO
  } calc_state_e;

endpackage

// File: rtl/lo_band_select.sv
module lo_band_select
  import lo_param_pkg::*;
#(
  parameter int FREQ_W = 33
) (
  input  logic [FREQ_W-1:0] freq_i,
  output logic              in_range_o,
  output logic [CODE_W-1:0] code_o,
  output logic [FREQ_W:0]   vco_o
);

  localparam int WIDE_W = FREQ_W + MAX_DOUBLINGS;

  // A target is usable only strictly below the VCO floor and at or above the minimum.
  assign in_range_o = (64'(freq_i) >= TARGET_MIN_HZ) && (64'(freq_i) < VCO_LOW_HZ);

  // Take the smallest doubling count that reaches the VCO floor; the code is that count minus one.
  always_comb begin
    logic [WIDE_W-1:0] scaled;
    logic              found;
    found  = 1'b0;
    code_o = '0;
    for (int k = 1; k <= int'(MAX_DOUBLINGS); k++) begin
      scaled = WIDE_W'(freq_i) << k;
      if (!found && (64'(scaled) >= VCO_LOW_HZ)) begin
        found  = 1'b1;
        code_o = CODE_W'(k - 1);
      end
    end
  end

  assign vco_o = {1'b0, freq_i} << ({1'b0, code_o} + 4'd1);

endmodule

// File: rtl/lo_restoring_div.sv
module lo_restoring_div #(
  parameter int DVD_W = 58,
  parameter int DVS_W = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o,
  output logic [DVS_W-1:0] rem_o
);

  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] rem_q, rem_n;
  logic [DVD_W-1:0] quot_q, quot_n;
  logic [DVS_W-1:0] dvs_q, dvs_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n;
  logic             done_q, done_n;

  logic [DVS_W:0]   shifted;
  logic [DVS_W-1:0] diff;
  logic             fits;

  assign shifted = {rem_q, quot_q[DVD_W-1]};
  assign fits    = shifted >= {1'b0, dvs_q};
  assign diff    = shifted[DVS_W-1:0] - dvs_q;

  always_comb begin
    rem_n  = rem_q;
    quot_n = quot_q;
    dvs_n  = dvs_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (go_i) begin
      rem_n  = '0;
      quot_n = dividend_i;
      dvs_n  = divisor_i;
      cnt_n  = CNT_W'(DVD_W);
      busy_n = 1'b1;
    end else if (busy_q) begin
      rem_n  = fits ? diff : shifted[DVS_W-1:0];
      quot_n = {quot_q[DVD_W-2:0], fits};
      cnt_n  = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quot_q <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      quot_q <= quot_n;
      dvs_q  <= dvs_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign done_o = done_q;
  assign quot_o = quot_q;
  assign rem_o  = rem_q;

  // R3
  rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < dvs_q));

endmodule

// File: rtl/lo_param_calc.sv
module lo_param_calc
  import lo_param_pkg::*;
#(
  parameter int FREQ_W = 33,
  parameter int REF_W  = 32,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [REF_W-1:0]  ref_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [CODE_W-1:0] code_o,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [FREQ_W:0]   vco_o,
  output logic [FREQ_W-1:0] lo_o
);

  localparam int VCO_W  = FREQ_W + 1;
  localparam int IW_W   = VCO_W + 1;
  localparam int DVS_W  = REF_W + 1;
  localparam int DVD_W  = VCO_W + FRAC_W + 1;
  localparam int QF_W   = FRAC_W + 1;
  localparam logic [DVD_W-1:0] MOD_D = DVD_W'(FRAC_MODULUS);
  localparam logic [QF_W-1:0]  MOD_Q = QF_W'(FRAC_MODULUS);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  // Band selection
  logic              band_ok;
  logic [CODE_W-1:0] band_code;
  logic [VCO_W-1:0]  band_vco;

  lo_band_select #(.FREQ_W(FREQ_W)) u_band (
    .freq_i     (freq_i),
    .in_range_o (band_ok),
    .code_o     (band_code),
    .vco_o      (band_vco)
  );

  // State
  calc_state_e       state_q, state_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [VCO_W-1:0]  vco_q, vco_n;
  logic [REF_W-1:0]  ref_q, ref_n;
  logic [REF_W-1:0]  rem1_q, rem1_n;
  logic [IW_W-1:0]   intw_q, intw_n;
  logic [FRAC_W-1:0] frac_q, frac_n;
  logic [DVD_W-1:0]  dvd_q, dvd_n;
  logic [DVS_W-1:0]  dvs_q, dvs_n;
  logic              go_q, go_n;
  logic              done_q, done_n;
  logic              err_q, err_n;
  logic [CODE_W-1:0] ocode_q, ocode_n;
  logic [INT_W-1:0]  oint_q, oint_n;
  logic [FRAC_W-1:0] ofrac_q, ofrac_n;
  logic [VCO_W-1:0]  ovco_q, ovco_n;
  logic [FREQ_W-1:0] olo_q, olo_n;

  // Shared divider
  logic             div_done;
  logic [DVD_W-1:0] div_quot;
  logic [DVS_W-1:0] div_rem;

  lo_restoring_div #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .go_i       (go_q),
    .dividend_i (dvd_q),
    .divisor_i  (dvs_q),
    .done_o     (div_done),
    .quot_o     (div_quot),
    .rem_o      (div_rem)
  );

  // Datapath between divider passes
  logic [DVD_W-1:0]  num_frac;
  logic [QF_W-1:0]   frac_raw;
  logic              carry;
  logic [FRAC_W-1:0] frac_adj;
  logic [IW_W-1:0]   int_sum;
  logic              int_ovf;
  logic [DVD_W-1:0]  y_lo;
  logic [DVD_W-1:0]  lo_dvd;
  logic [DVS_W-1:0]  lo_dvs;
  logic [CODE_W:0]   shamt;
  logic [FREQ_W-1:0] lo_val;

  // Rounded fraction: floor((2*r*M + ref) / (2*ref))
  assign num_frac = ((DVD_W'(div_rem[REF_W-1:0]) * MOD_D) << 1) + DVD_W'(ref_q);
  assign frac_raw = div_quot[QF_W-1:0];
  assign carry    = frac_raw >= MOD_Q;
  assign frac_adj = FRAC_W'(carry ? (frac_raw - MOD_Q) : frac_raw);
  assign int_sum  = intw_q + IW_W'(carry);
  assign int_ovf  = |int_sum[IW_W-1:INT_W];
  // ref*(int*M + frac) equals M*(vco - r) + ref*frac_raw, with or without the carry
  assign y_lo     = (DVD_W'(vco_q - VCO_W'(rem1_q)) * MOD_D) + (DVD_W'(ref_q) * DVD_W'(frac_raw));
  assign shamt    = {1'b0, code_q} + 1'b1;
  assign lo_dvd   = y_lo + (MOD_D << code_q);
  assign lo_dvs   = DVS_W'(FRAC_MODULUS) << shamt;
  assign lo_val   = div_quot[FREQ_W-1:0];

  always_comb begin
    state_n = state_q;
    code_n  = code_q;
    vco_n   = vco_q;
    ref_n   = ref_q;
    rem1_n  = rem1_q;
    intw_n  = intw_q;
    frac_n  = frac_q;
    dvd_n   = dvd_q;
    dvs_n   = dvs_q;
    go_n    = 1'b0;
    done_n  = 1'b0;
    err_n   = err_q;
    ocode_n = ocode_q;
    oint_n  = oint_q;
    ofrac_n = ofrac_q;
    ovco_n  = ovco_q;
    olo_n   = olo_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!band_ok || (ref_i == '0)) begin
            done_n  = 1'b1;
            err_n   = 1'b1;
            ocode_n = '0;
            oint_n  = '0;
            ofrac_n = '0;
            ovco_n  = '0;
            olo_n   = '0;
          end else begin
            code_n  = band_code;
            vco_n   = band_vco;
            ref_n   = ref_i;
            dvd_n   = DVD_W'(band_vco);
            dvs_n   = DVS_W'(ref_i);
            go_n    = 1'b1;
            state_n = ST_INT;
          end
        end
      end
      ST_INT: begin
        if (div_done) begin
          rem1_n  = div_rem[REF_W-1:0];
          intw_n  = IW_W'(div_quot[VCO_W-1:0]);
          dvd_n   = num_frac;
          dvs_n   = {ref_q, 1'b0};
          go_n    = 1'b1;
          state_n = ST_FRAC;
        end
      end
      ST_FRAC: begin
        if (div_done) begin
          if (int_ovf) begin
            done_n  = 1'b1;
            err_n   = 1'b1;
            ocode_n = '0;
            oint_n  = '0;
            ofrac_n = '0;
            ovco_n  = '0;
            olo_n   = '0;
            state_n = ST_IDLE;
          end else begin
            intw_n  = int_sum;
            frac_n  = frac_adj;
            dvd_n   = lo_dvd;
            dvs_n   = lo_dvs;
            go_n    = 1'b1;
            state_n = ST_LO;
          end
        end
      end
      ST_LO: begin
        if (div_done) begin
          done_n  = 1'b1;
          err_n   = 1'b0;
          ocode_n = code_q;
          oint_n  = intw_q[INT_W-1:0];
          ofrac_n = frac_q;
          olo_n   = lo_val;
          ovco_n  = {1'b0, lo_val} << shamt;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      vco_q   <= '0;
      ref_q   <= '0;
      rem1_q  <= '0;
      intw_q  <= '0;
      frac_q  <= '0;
      dvd_q   <= '0;
      dvs_q   <= '0;
      go_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ocode_q <= '0;
      oint_q  <= '0;
      ofrac_q <= '0;
      ovco_q  <= '0;
      olo_q   <= '0;
    end else begin
      state_q <= state_n;
      code_q  <= code_n;
      vco_q   <= vco_n;
      ref_q   <= ref_n;
      rem1_q  <= rem1_n;
      intw_q  <= intw_n;
      frac_q  <= frac_n;
      dvd_q   <= dvd_n;
      dvs_q   <= dvs_n;
      go_q    <= go_n;
      done_q  <= done_n;
      err_q   <= err_n;
      ocode_q <= ocode_n;
      oint_q  <= oint_n;
      ofrac_q <= ofrac_n;
      ovco_q  <= ovco_n;
      olo_q   <= olo_n;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;
  assign code_o  = ocode_q;
  assign int_o   = oint_q;
  assign frac_o  = ofrac_q;
  assign vco_o   = ovco_q;
  assign lo_o    = olo_q;

  // R2
  vco_window_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_INT) |-> ((64'(vco_q) >= VCO_LOW_HZ) && (64'(vco_q) < VCO_HIGH_HZ)));

  // R4
  frac_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_q && !err_q) |-> (64'(ofrac_q) < FRAC_MODULUS));

  // R1
  err_cleared_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_q && err_q) |-> ((ocode_q == '0) && (oint_q == '0) && (ofrac_q == '0)
                           && (ovco_q == '0) && (olo_q == '0)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_q |-> !busy_o);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && start_i) |=> ($stable(ref_q) && $stable(code_q)));

  // R3
  quot_width_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    div_done |-> ((div_quot[DVD_W-1:VCO_W] == '0) && !div_rem[DVS_W-1]));

endmodule

// File: tb/lo_param_calc_test.sv
module lo_param_calc_test;

  localparam int CLK_PERIOD = 10;
  localparam int INT_W      = 16;
  localparam int NVEC       = 14;
  localparam logic [127:0] MODV = 128'd8388593;

  localparam logic [32:0] VEC_F [NVEC] = '{
    33'd2400000000, 33'd5900000000, 33'd3000000000, 33'd46875000,
    33'd46874999,   33'd6000000000, 33'd6000000001, 33'd1000000000,
    33'd100000000,  33'd915123457,  33'd433920000,  33'd2400000000,
    33'd2400000000, 33'd5999999999};
  localparam logic [31:0] VEC_R [NVEC] = '{
    32'd80000000, 32'd80000000, 32'd80000000, 32'd80000000,
    32'd80000000, 32'd80000000, 32'd80000000, 32'd40000000,
    32'd61440000, 32'd40000000, 32'd61440000, 32'd0,
    32'd100000,   32'd80000000};
  localparam bit VEC_E [NVEC] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int VEC_C [NVEC] = '{1, 0, 0, 6, 0, 0, 0, 2, 5, 2, 3, 0, 0, 0};

  logic        clk, rst_n, start_i;
  logic [32:0] freq_i;
  logic [31:0] ref_i;
  logic        busy_o, done_o, error_o;
  logic [2:0]  code_o;
  logic [15:0] int_o;
  logic [22:0] frac_o;
  logic [33:0] vco_o;
  logic [32:0] lo_o;

  int checks = 0;
  int fails  = 0;

  lo_param_calc #(.FREQ_W(33), .REF_W(32), .INT_W(INT_W), .FRAC_W(23)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .freq_i(freq_i), .ref_i(ref_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .code_o(code_o),
    .int_o(int_o), .frac_o(frac_o), .vco_o(vco_o), .lo_o(lo_o));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference computation taken from the requirements.
  function automatic void model(input logic [127:0] f, input logic [127:0] r,
                                output bit e, output logic [127:0] c, output logic [127:0] iw,
                                output logic [127:0] fr, output logic [127:0] lo,
                                output logic [127:0] vc);
    logic [127:0] t, rm, scale;
    int n;
    e = 1'b0; c = 0; iw = 0; fr = 0; lo = 0; vc = 0;
    if (f >= 128'd6000000000 || f < 128'd46875000 || r == 0) begin
      e = 1'b1;
      return;
    end
    t = f; n = 0;
    while (t < 128'd6000000000) begin
      t = t * 2;
      n++;
    end
    c = n - 1;
    iw = t / r;
    rm = t % r;
    fr = (2 * rm * MODV + r) / (2 * r);
    if (fr >= MODV) begin
      fr = fr - MODV;
      iw = iw + 1;
    end
    if (iw >= (128'd1 << INT_W)) begin
      e = 1'b1; c = 0; iw = 0; fr = 0;
      return;
    end
    scale = 128'd1 << (c + 1);
    lo = (2 * r * (iw * MODV + fr) + MODV * scale) / (2 * MODV * scale);
    vc = lo * scale;
  endfunction

  task automatic kick(input logic [32:0] f, input logic [31:0] r);
    @(negedge clk);
    freq_i  = f;
    ref_i   = r;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done_o) begin
        ok = 1'b1;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_result(input logic [32:0] f, input logic [31:0] r, input string lbl);
    bit e;
    logic [127:0] c, iw, fr, lo, vc;
    model(f, r, e, c, iw, fr, lo, vc);
    chk({lbl, " R1/R8 error flag"}, error_o, e);
    chk({lbl, " R2 divider code"}, code_o, c);
    chk({lbl, " R3 integer word"}, int_o, iw);
    chk({lbl, " R4 fractional word"}, frac_o, fr);
    chk({lbl, " R6 LO frequency"}, lo_o, lo);
    chk({lbl, " R7 VCO frequency"}, vco_o, vc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    rst_n = 1'b0; start_i = 1'b0; freq_i = '0; ref_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 busy after reset", busy_o, 0);
    chk("R11 done after reset", done_o, 0);
    chk("R11 error after reset", error_o, 0);
    chk("R11 outputs after reset", {code_o, int_o, frac_o, vco_o, lo_o}, 0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      string lbl;
      lbl = $sformatf("vec%0d", v);
      kick(VEC_F[v], VEC_R[v]);
      wait_done(ok);
      chk({lbl, " R9 completion seen"}, ok, 1);
      chk({lbl, " R1/R8 error as tabulated"}, error_o, VEC_E[v]);
      chk({lbl, " R2 code as tabulated"}, code_o, VEC_C[v]);
      check_result(VEC_F[v], VEC_R[v], lbl);
      if (VEC_E[v])
        chk({lbl, " R1 outputs cleared"}, {code_o, int_o, frac_o, vco_o, lo_o}, 0);
    end

    // R5: fraction rounds to the full modulus and carries into the integer word
    kick(33'd3999999999, 32'd40000000);
    wait_done(ok);
    chk("R5 carry completion", ok, 1);
    chk("R5 carry integer word", int_o, 200);
    chk("R5 carry fractional word", frac_o, 0);
    chk("R6 carry LO frequency", lo_o, 64'd4000000000);
    chk("R7 carry VCO frequency", vco_o, 64'd8000000000);
    check_result(33'd3999999999, 32'd40000000, "carry");

    // R9: handshake timing, hold, error cleared by success
    kick(33'd6000000001, 32'd80000000);
    wait_done(ok);
    chk("R9 error precedes success", error_o, 1);
    kick(33'd2400000000, 32'd80000000);
    chk("R9 busy one cycle after start", busy_o, 1);
    chk("R9 no done while busy", done_o, 0);
    wait_done(ok);
    chk("R9 busy low with done", busy_o, 0);
    chk("R9 success clears error", error_o, 0);
    @(negedge clk);
    chk("R9 done lasts one cycle", done_o, 0);
    chk("R9 integer word held", int_o, 120);
    chk("R9 fraction held", frac_o, 0);
    chk("R9 LO held", lo_o, 64'd2400000000);

    // R10: a second start during a run is ignored
    kick(33'd2400000000, 32'd80000000);
    repeat (5) @(negedge clk);
    freq_i  = 33'd1000000000;
    ref_i   = 32'd40000000;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10 still busy after ignored start", busy_o, 1);
    wait_done(ok);
    chk("R10 code from first request", code_o, 1);
    chk("R10 integer word from first request", int_o, 120);
    chk("R10 LO from first request", lo_o, 64'd2400000000);
    @(negedge clk);
    chk("R10 no second completion", done_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule